// File: doc/BRIEF.md
# Host-Side Flash Card Bus Sequencer

This block turns single host requests into timed bus cycles on a removable 16-bit flash card. A request carries a byte address, a byte/word flag, a direction and write data. The block keeps the card address stable for one cycle before it selects the card. It then lowers the byte-lane enables that the access needs, pulses the read or write strobe for a programmed width, and holds the enables for a programmed time. Last, it returns one response to the host.

Host address bit 0 never reaches the card. Together with the byte flag, bit 0 picks one or both lanes. An odd byte always travels on the upper lane, and bytes are never swapped. Write requests wait while the card reports busy. When the card is write-protected, a write request ends at once with an error and no strobe.

After the block reset, or when the host asks for it, the block drives a card reset pulse. It then waits a recovery interval before it accepts work.

Top module: `mcard_host_ctrl`

## Requirements
- R1: `card_addr` equals host address bits [25:1] of the accepted request. It is set one cycle before any enable falls and does not change while an enable is low.
- R2: Lane enables (active low, lane 0 = bits 7:0, lane 1 = bits 15:8) follow the accepted request. In word mode both lanes are enabled whatever bit 0 is. In byte mode with bit 0 = 0 only lane 0 is enabled, and with bit 0 = 1 only lane 1 is enabled.
- R3: During a write, `card_d_oe[i]` is 1 exactly for the enabled lanes, and the lane carries the same lane of `req_wdata` without swapping. A disabled lane stays released.
- R4: Read data is captured on the last cycle of the OE# pulse. It is returned on `rsp_rdata` in place, with the bits of disabled lanes forced to zero.
- R5: After the accept edge the cycle runs as follows: one address-only cycle; SETUP_CYC cycles with enables low and strobes high; PULSE_CYC cycles with the strobe low; HOLD_CYC cycles with enables low and strobes high. Write data stays driven until the hold ends. `rsp_valid` is high for the single cycle after the hold.
- R6: A read pulses only `card_oe_n`, and a write pulses only `card_we_n`. The two are never low together.
- R7: Between cycles both enables are high, `card_d_oe` is zero and both strobes are high.
- R8: While the synchronised `card_busy_n` is low, a write request is not accepted (`req_ready` low). A read request is still accepted.
- R9: After `rst_n` is released, and after a `card_reset_req` that is sampled while idle, `card_rst_n` is low for RST_PULSE_CYC cycles. It is then high for RST_RECOV_CYC cycles with `req_ready` low before `req_ready` may rise.
- R10: With `card_wp` high, an accepted write produces `rsp_valid` and `rsp_err` high in the next cycle and no WE# or enable activity.
- R11: `req_ready` stays low from the accept edge until the cycle is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 26 | Host byte address |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, odd byte in bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write refused because of write protection |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| card_reset_req | input | 1 | Request a card reset pulse |
| card_addr | output | 25 | Card word address |
| card_cel_n | output | 1 | Low-lane enable, active low |
| card_ceh_n | output | 1 | High-lane enable, active low |
| card_oe_n | output | 1 | Read strobe, active low |
| card_we_n | output | 1 | Write strobe, active low |
| card_d_o | output | 16 | Data driven to the card |
| card_d_oe | output | 2 | Per-lane drive enable |
| card_d_i | input | 16 | Data from the card |
| card_busy_n | input | 1 | Card busy, active low |
| card_wp | input | 1 | Card write-protect status |
| card_rst_n | output | 1 | Card reset, active low |

## Verification
The bench builds the block with SETUP_CYC=2, PULSE_CYC=3, HOLD_CYC=1, RST_PULSE_CYC=4 and RST_RECOV_CYC=20. With these values every phase lasts a different number of cycles, so a phase that is one cycle too long or too short, or two phases that are swapped, shows up as a wrong count. The short recovery makes the full power-on and host-requested reset sequence cheap to measure exactly. BUSY_SYNC=2 leaves the synchroniser in the path, so the busy hold-off is tested through the same latency the block uses in a real system.

// File: rtl/mcard_pkg.sv
package mcard_pkg;

   typedef enum logic [2:0] {
      ST_RST_PULSE,
      ST_RST_WAIT,
      ST_IDLE,
      ST_ADDR,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD
   } seq_state_t;

   // Active-high lane selection {high, low} for a given address bit 0 and byte flag.
   function automatic logic [1:0] lanes_for(input logic a0, input logic byte_mode);
      if (!byte_mode)
         return 2'b11;
      else if (a0)
         return 2'b10;
      else
         return 2'b01;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mcard_lane_map.sv
module mcard_lane_map
   import mcard_pkg::*;
(
   input  logic       a0,
   input  logic       byte_mode,
   input  logic       active,
   output logic [1:0] lane_en,
   output logic       cel_n,
   output logic       ceh_n
);

   always_comb begin
      lane_en = lanes_for(a0, byte_mode);
      cel_n   = !(active && lane_en[0]);
      ceh_n   = !(active && lane_en[1]);
   end

   // R2: a byte access selects exactly one lane
   always_comb begin
      if (active && byte_mode)
         a_r2_byte_single_lane: assert ($countones({cel_n, ceh_n}) == 1);
   end

endmodule

// File: rtl/mcard_busy_sync.sv
module mcard_busy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_n_in,
   output logic ready_o
);

   generate
      if (STAGES == 0) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign ready_o = busy_n_in;
      end else begin : g_sync
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= busy_n_in;
               for (int i = 1; i < STAGES; i++)
                  sr[i] <= sr[i-1];
            end
         end
         assign ready_o = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mcard_seq.sv
module mcard_seq
   import mcard_pkg::*;
#(
   parameter int SETUP_CYC     = 2,
   parameter int PULSE_CYC     = 3,
   parameter int HOLD_CYC      = 1,
   parameter int RST_PULSE_CYC = 10,
   parameter int RST_RECOV_CYC = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       reset_req,
   output seq_state_t state,
   output logic       strobe_last,
   output logic       hold_last
);

   localparam int MAX_CYC = max_of(max_of(max_of(SETUP_CYC, PULSE_CYC), HOLD_CYC),
                                   max_of(RST_PULSE_CYC, RST_RECOV_CYC));
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] L_RSTP  = CNT_W'(RST_PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] L_RECOV = CNT_W'(RST_RECOV_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;

   assign cnt_zero    = (cnt == '0);
   assign strobe_last = (state == ST_STROBE) && cnt_zero;
   assign hold_last   = (state == ST_HOLD) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RST_PULSE;
         cnt   <= L_RSTP;
      end else begin
         case (state)
            ST_RST_PULSE: begin
               if (cnt_zero) begin
                  state <= ST_RST_WAIT;
                  cnt   <= L_RECOV;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_RST_WAIT: begin
               if (cnt_zero) state <= ST_IDLE;
               else          cnt   <= cnt - 1'b1;
            end
            ST_IDLE: begin
               if (reset_req) begin
                  state <= ST_RST_PULSE;
                  cnt   <= L_RSTP;
               end else if (start) begin
                  state <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               state <= ST_SETUP;
               cnt   <= L_SETUP;
            end
            ST_SETUP: begin
               if (cnt_zero) begin
                  state <= ST_STROBE;
                  cnt   <= L_PULSE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_STROBE: begin
               if (cnt_zero) begin
                  state <= ST_HOLD;
                  cnt   <= L_HOLD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt_zero) state <= ST_IDLE;
               else          cnt   <= cnt - 1'b1;
            end
            default: begin
               state <= ST_RST_PULSE;
               cnt   <= L_RSTP;
            end
         endcase
      end
   end

   // R9: recovery is only ever entered from the reset pulse
   a_r9_recover_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RST_WAIT && $past(state) != ST_RST_WAIT) |-> $past(state) == ST_RST_PULSE);

   // R5: a strobe phase is always followed by the hold phase
   a_r5_strobe_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STROBE) |=> (state == ST_STROBE || state == ST_HOLD));

   // R5: setup is only reached through the address-only cycle
   a_r5_addr_before_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_SETUP) |-> $past(state) == ST_ADDR);

endmodule

// File: rtl/mcard_host_ctrl.sv
module mcard_host_ctrl
   import mcard_pkg::*;
#(
   parameter int HADDR_W       = 26,
   parameter int LANE_W        = 8,
   parameter int SETUP_CYC     = 2,
   parameter int PULSE_CYC     = 3,
   parameter int HOLD_CYC      = 1,
   parameter int RST_PULSE_CYC = 10,
   parameter int RST_RECOV_CYC = 2000,
   parameter int BUSY_SYNC     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [HADDR_W-1:0]   req_addr,
   input  logic                 req_byte,
   input  logic                 req_write,
   input  logic [2*LANE_W-1:0]  req_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [2*LANE_W-1:0]  rsp_rdata,
   input  logic                 card_reset_req,
   output logic [HADDR_W-2:0]   card_addr,
   output logic                 card_cel_n,
   output logic                 card_ceh_n,
   output logic                 card_oe_n,
   output logic                 card_we_n,
   output logic [2*LANE_W-1:0]  card_d_o,
   output logic [1:0]           card_d_oe,
   input  logic [2*LANE_W-1:0]  card_d_i,
   input  logic                 card_busy_n,
   input  logic                 card_wp,
   output logic                 card_rst_n
);

   localparam int CADDR_W = HADDR_W - 1;
   localparam int DATA_W  = 2 * LANE_W;
   localparam int N_LANES = 2;

   generate
      if (HADDR_W < 2)       begin : g_bad_aw  $error("HADDR_W must be at least 2"); end
      if (LANE_W < 1)        begin : g_bad_lw  $error("LANE_W must be positive"); end
      if (SETUP_CYC < 1)     begin : g_bad_su  $error("SETUP_CYC must be at least 1"); end
      if (PULSE_CYC < 1)     begin : g_bad_pw  $error("PULSE_CYC must be at least 1"); end
      if (HOLD_CYC < 1)      begin : g_bad_ho  $error("HOLD_CYC must be at least 1"); end
      if (RST_PULSE_CYC < 1) begin : g_bad_rp  $error("RST_PULSE_CYC must be at least 1"); end
      if (RST_RECOV_CYC < 1) begin : g_bad_rr  $error("RST_RECOV_CYC must be at least 1"); end
      if (BUSY_SYNC < 0)     begin : g_bad_bs  $error("BUSY_SYNC must not be negative"); end
   endgenerate

   seq_state_t          state;
   logic                strobe_last;
   logic                hold_last;
   logic                busy_ok;
   logic                idle;
   logic                accept;
   logic                wp_hit;
   logic                start;
   logic                active;
   logic [1:0]          lane_en;

   logic [CADDR_W-1:0]  addr_q;
   logic                a0_q;
   logic                byte_q;
   logic                wr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W-1:0]   rd_word;
   logic [N_LANES-1:0]  drive;

   mcard_busy_sync #(.STAGES(BUSY_SYNC)) busy_sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_n_in (card_busy_n),
      .ready_o   (busy_ok)
   );

   assign idle      = (state == ST_IDLE);
   assign req_ready = idle && !card_reset_req && (!req_write || card_wp || busy_ok);
   assign accept    = req_valid && req_ready;
   assign wp_hit    = accept && req_write && card_wp;
   assign start     = accept && !wp_hit;

   mcard_seq #(
      .SETUP_CYC     (SETUP_CYC),
      .PULSE_CYC     (PULSE_CYC),
      .HOLD_CYC      (HOLD_CYC),
      .RST_PULSE_CYC (RST_PULSE_CYC),
      .RST_RECOV_CYC (RST_RECOV_CYC)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .reset_req   (card_reset_req),
      .state       (state),
      .strobe_last (strobe_last),
      .hold_last   (hold_last)
   );

   assign active = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

   mcard_lane_map lane_map_i (
      .a0        (a0_q),
      .byte_mode (byte_q),
      .active    (active),
      .lane_en   (lane_en),
      .cel_n     (card_cel_n),
      .ceh_n     (card_ceh_n)
   );

   // Request capture: host bit 0 steers lanes only, never the card address.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         a0_q    <= 1'b0;
         byte_q  <= 1'b0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else if (start) begin
         addr_q  <= req_addr[HADDR_W-1:1];
         a0_q    <= req_addr[0];
         byte_q  <= req_byte;
         wr_q    <= req_write;
         wdata_q <= req_wdata;
      end
   end

   // Per-lane data steering, same lane in both directions.
   generate
      for (genvar g = 0; g < N_LANES; g++) begin : g_lane
         assign drive[g] = active && wr_q && lane_en[g];
         assign card_d_oe[g] = drive[g];
         assign card_d_o[g*LANE_W +: LANE_W] = drive[g] ? wdata_q[g*LANE_W +: LANE_W] : '0;
         assign rd_word[g*LANE_W +: LANE_W]  = lane_en[g] ? card_d_i[g*LANE_W +: LANE_W] : '0;
      end
   endgenerate

   assign card_addr  = addr_q;
   assign card_oe_n  = !((state == ST_STROBE) && !wr_q);
   assign card_we_n  = !((state == ST_STROBE) && wr_q);
   assign card_rst_n = (state != ST_RST_PULSE);

   // Response path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= hold_last || wp_hit;
         rsp_err   <= wp_hit;
         if (start || wp_hit)
            rsp_rdata <= '0;
         else if (strobe_last && !wr_q)
            rsp_rdata <= rd_word;
      end
   end

   // R6: strobes are mutually exclusive
   a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!card_oe_n && !card_we_n));

   // R6: a strobe is only issued while some lane is enabled
   a_r6_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_oe_n || !card_we_n) |-> (!card_cel_n || !card_ceh_n));

   // R7: deselected card means released data bus
   a_r7_standby_released: assert property (@(posedge clk) disable iff (!rst_n)
      (card_cel_n && card_ceh_n) |-> (card_d_oe == 2'b00));

   // R1: address does not move while the card is selected
   a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_cel_n || !card_ceh_n) |-> $stable(card_addr));

   // R3: a lane is only driven while that lane is enabled
   a_r3_drive_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
      card_d_oe[0] |-> !card_cel_n);
   a_r3_drive_high_lane: assert property (@(posedge clk) disable iff (!rst_n)
      card_d_oe[1] |-> !card_ceh_n);

   // R10: a refused write answers with an error and no write strobe
   a_r10_wp_refusal: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |=> (rsp_valid && rsp_err && card_we_n && card_cel_n && card_ceh_n));

endmodule

// File: tb/mcard_host_ctrl_tb.sv
module mcard_host_ctrl_tb_top;

   localparam int SETUP  = 2;
   localparam int PULSE  = 3;
   localparam int HOLD   = 1;
   localparam int RSTP   = 4;
   localparam int RECOV  = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [25:0] req_addr = '0;
   logic        req_byte = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [15:0] rsp_rdata;
   logic        card_reset_req = 1'b0;
   logic [24:0] card_addr;
   logic        card_cel_n;
   logic        card_ceh_n;
   logic        card_oe_n;
   logic        card_we_n;
   logic [15:0] card_d_o;
   logic [1:0]  card_d_oe;
   logic [15:0] card_d_i;
   logic        card_busy_n = 1'b1;
   logic        card_wp = 1'b0;
   logic        card_rst_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   // Simple card model: read data is a function of the card address.
   assign card_d_i = {card_addr[7:0] ^ 8'hC3, card_addr[15:8] ^ 8'h5A};

   mcard_host_ctrl #(
      .SETUP_CYC     (SETUP),
      .PULSE_CYC     (PULSE),
      .HOLD_CYC      (HOLD),
      .RST_PULSE_CYC (RSTP),
      .RST_RECOV_CYC (RECOV),
      .BUSY_SYNC     (2)
   ) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_addr       (req_addr),
      .req_byte       (req_byte),
      .req_write      (req_write),
      .req_wdata      (req_wdata),
      .rsp_valid      (rsp_valid),
      .rsp_err        (rsp_err),
      .rsp_rdata      (rsp_rdata),
      .card_reset_req (card_reset_req),
      .card_addr      (card_addr),
      .card_cel_n     (card_cel_n),
      .card_ceh_n     (card_ceh_n),
      .card_oe_n      (card_oe_n),
      .card_we_n      (card_we_n),
      .card_d_o       (card_d_o),
      .card_d_oe      (card_d_oe),
      .card_d_i       (card_d_i),
      .card_busy_n    (card_busy_n),
      .card_wp        (card_wp),
      .card_rst_n     (card_rst_n)
   );

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // Vector: {write, byte, addr[25:0], wdata[15:0]}
   localparam int NV = 7;
   localparam logic [43:0] VEC [NV] = '{
      {1'b0, 1'b0, 26'h1234568, 16'h0000},
      {1'b0, 1'b1, 26'h2ABCDE0, 16'h0000},
      {1'b0, 1'b1, 26'h3FFFFFF, 16'h0000},
      {1'b0, 1'b0, 26'h0000001, 16'h0000},
      {1'b1, 1'b0, 26'h0000010, 16'hBEEF},
      {1'b1, 1'b1, 26'h1000002, 16'h12C3},
      {1'b1, 1'b1, 26'h0F0F0F1, 16'h5A77}
   };

   // Hand a request over; returns at the negedge right after the accept edge.
   task automatic issue(input bit wr, input bit byt, input logic [25:0] a, input logic [15:0] wd);
      req_write = wr;
      req_byte  = byt;
      req_addr  = a;
      req_wdata = wd;
      req_valid = 1'b1;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_txn(input bit wr, input bit byt, input logic [25:0] a, input logic [15:0] wd);
      logic [24:0] ca;
      bit          exp_lo, exp_hi;
      logic [15:0] exp_rd;
      int          n_setup, n_pulse, n_hold;
      bit          addr_ok, lane_ok, data_ok, strobe_ok, ready_ok, pre_ok;
      ca     = a[25:1];
      exp_lo = !byt || !a[0];
      exp_hi = !byt || a[0];
      exp_rd = {exp_hi ? (ca[7:0] ^ 8'hC3) : 8'h00, exp_lo ? (ca[15:8] ^ 8'h5A) : 8'h00};
      n_setup = 0; n_pulse = 0; n_hold = 0;
      addr_ok = 1; lane_ok = 1; data_ok = 1; strobe_ok = 1; ready_ok = 1;
      issue(wr, byt, a, wd);
      // address-only cycle
      pre_ok = (card_addr == ca) && card_cel_n && card_ceh_n && !req_ready;
      check(pre_ok, "R1 address set before enables", {card_addr, card_cel_n, card_ceh_n},
            {ca, 2'b11});
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (card_cel_n && card_ceh_n) break;
         if (card_addr != ca) addr_ok = 0;
         if (req_ready) ready_ok = 0;
         if ({!card_ceh_n, !card_cel_n} != {exp_hi, exp_lo}) lane_ok = 0;
         if (wr) begin
            if (card_d_oe != {exp_hi, exp_lo}) data_ok = 0;
            if (exp_lo && card_d_o[7:0] != wd[7:0]) data_ok = 0;
            if (exp_hi && card_d_o[15:8] != wd[15:8]) data_ok = 0;
         end else if (card_d_oe != 2'b00) begin
            data_ok = 0;
         end
         if (!card_oe_n || !card_we_n) begin
            n_pulse++;
            if (wr ? (card_we_n || !card_oe_n) : (card_oe_n || !card_we_n)) strobe_ok = 0;
         end else if (n_pulse == 0) begin
            n_setup++;
         end else begin
            n_hold++;
         end
      end
      check(addr_ok, "R1 card address during cycle", card_addr, ca);
      check(lane_ok, "R2 lane enables", {!card_ceh_n, !card_cel_n}, {exp_hi, exp_lo});
      check(data_ok, wr ? "R3 write lane drive" : "R3 read leaves bus released", card_d_oe, {exp_hi, exp_lo});
      check(strobe_ok, "R6 strobe kind", {card_oe_n, card_we_n}, {wr, !wr});
      check(n_setup == SETUP && n_pulse == PULSE && n_hold == HOLD, "R5 phase lengths",
            {n_setup[15:0], n_pulse[15:0], n_hold[15:0]}, {16'(SETUP), 16'(PULSE), 16'(HOLD)});
      check(ready_ok, "R11 ready low during cycle", 1, 0);
      check(rsp_valid && !rsp_err, "R5 response pulse", {rsp_valid, rsp_err}, 2'b10);
      check(card_d_oe == 2'b00 && card_oe_n && card_we_n, "R7 standby after cycle",
            {card_d_oe, card_oe_n, card_we_n}, 4'b0011);
      if (!wr)
         check(rsp_rdata == exp_rd, "R4 read data in place", rsp_rdata, exp_rd);
      @(negedge clk);
      check(!rsp_valid, "R5 response lasts one cycle", rsp_valid, 0);
   endtask

   task automatic measure_reset(input string tag);
      int n_low, n_wait;
      bit ready_seen;
      n_low = 0; n_wait = 0; ready_seen = 0;
      for (int k = 0; k < 200 && !card_rst_n; k++) begin
         n_low++;
         @(negedge clk);
      end
      for (int k = 0; k < 200 && !req_ready; k++) begin
         if (!card_rst_n) ready_seen = 1;
         n_wait++;
         @(negedge clk);
      end
      check(n_low == RSTP, {"R9 reset pulse length ", tag}, n_low, RSTP);
      check(n_wait == RECOV && !ready_seen, {"R9 recovery length ", tag}, n_wait, RECOV);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      bit we_seen;
      // Reset state
      repeat (3) @(negedge clk);
      check(!card_rst_n && !req_ready && card_cel_n && card_ceh_n && card_oe_n && card_we_n
            && card_d_oe == 2'b00 && !rsp_valid, "R7 R9 state during reset",
            {card_rst_n, req_ready, card_cel_n, card_ceh_n, card_d_oe}, 6'b001100);
      rst_n = 1'b1;
      #1;
      measure_reset("after rst_n");

      // Vector table
      for (int v = 0; v < NV; v++)
         run_txn(VEC[v][43], VEC[v][42], VEC[v][41:16], VEC[v][15:0]);

      // Busy hold-off
      card_busy_n = 1'b0;
      repeat (4) @(negedge clk);
      req_write = 1'b1;
      req_valid = 1'b1;
      begin
         bit stalled;
         stalled = 1;
         for (int k = 0; k < 8; k++) begin
            #1;
            if (req_ready) stalled = 0;
            @(negedge clk);
         end
         check(stalled, "R8 write stalls while busy", 0, 0);
      end
      req_write = 1'b0;
      #1;
      check(req_ready, "R8 read accepted while busy", req_ready, 1);
      req_valid = 1'b0;
      run_txn(1'b0, 1'b1, 26'h0000101, 16'h0);
      card_busy_n = 1'b1;
      repeat (3) @(negedge clk);
      run_txn(1'b1, 1'b0, 26'h2222222, 16'hA55A);

      // Write protect
      card_wp = 1'b1;
      issue(1'b1, 1'b0, 26'h0000040, 16'h1111);
      check(rsp_valid && rsp_err, "R10 protected write errors at once", {rsp_valid, rsp_err}, 2'b11);
      we_seen = 0;
      for (int k = 0; k < 6; k++) begin
         if (!card_we_n || !card_cel_n || !card_ceh_n) we_seen = 1;
         @(negedge clk);
      end
      check(!we_seen, "R10 no write strobe when protected", we_seen, 0);
      card_wp = 1'b0;

      // Host-requested card reset
      card_reset_req = 1'b1;
      @(negedge clk);
      card_reset_req = 1'b0;
      measure_reset("on request");
      run_txn(1'b0, 1'b0, 26'h0000AAA, 16'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule